// File: doc/BRIEF.md
# Processor Interrupt Entry Sequencer

This block is the part of a processor control unit that decides, at every instruction boundary, whether the next instruction runs or a vectored interrupt entry starts instead. It owns the program counter and the 16-bit status word. When the single interrupt request is high and the status word's enable bit is set, it saves both registers and blocks further interrupts. It then raises acknowledge and takes a vector from the interrupting device. Two words are read from memory: the handler address, stored at the vector, and the handler priority, stored at the word after it.

When the priority word arrives, the sequencer writes its low three bits into the priority field and sets the enable bit again, so that a more urgent device can interrupt the handler. A return command puts the saved program counter and status word back in one cycle. Instruction execution stays outside the block. It updates the two registers through write strobes, and it moves to its next instruction when the block signals `proceed`.

Status word layout, which is fixed: bits 2:0 hold the execution priority, bit 3 is the interrupt enable, bits 7:4 hold the N, Z, V and C flags, and bits 15:8 are reserved for other uses.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `pc` equals RESET_PC (0), `psr` is 0, and `ack`, `mem_rd` and `proceed` are low.
- R2: In the idle state, a `boundary` with `irq` low, or with `psr[3]` low, drives `proceed` high in the same cycle, and no entry starts (`ack` stays low).
- R3: In the idle state, a `boundary` with `irq` high and `psr[3]` high drives `proceed` low. From the next cycle `ack` is high and `psr[3]` is 0, with the other status bits unchanged.
- R4: While `ack` is high, the first cycle with `vec_valid` high captures `vec_data`. From the next cycle `ack` is low and a read is issued with `mem_addr` equal to the zero-extended vector.
- R5: Each read holds `mem_rd` and `mem_addr` steady until `mem_ready` is high. On the cycle the first read completes, `pc` is loaded with `mem_rdata`, and the second read then goes to vector+1.
- R6: When the second read completes, `psr[2:0]` takes `mem_rdata[2:0]` and `psr[3]` becomes 1. Bits 15:4 keep their pre-entry values, and the upper bits of `mem_rdata` are ignored. `mem_rd` falls in the next cycle.
- R7: In the idle state, `ret` restores `pc` and `psr` to the values they had when the last entry began, on the next edge. A `boundary` in that cycle is ignored, so `proceed` is low and no entry starts.
- R8: `pc_wr` and `psr_wr` load `pc_wdata` and `psr_wdata` only in the idle state with `ret` low and no entry starting. During an entry sequence, `pc_wr`, `psr_wr` and `ret` have no effect.
- R9: While an entry sequence is in progress, `proceed` stays low whatever `boundary` and `irq` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | An instruction boundary is reached |
| irq | input | 1 | Interrupt request from the hub, active high |
| proceed | output | 1 | Next instruction may execute |
| ack | output | 1 | Interrupt acknowledge to the hub |
| vec_valid | input | 1 | Device is driving a vector |
| vec_data | input | VW (10) | Vector from the device |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | AW (16) | Memory read word address |
| mem_rdata | input | AW (16) | Memory read data |
| mem_ready | input | 1 | Read data valid; read completes |
| ret | input | 1 | Return from interrupt |
| pc_wr | input | 1 | Program counter write strobe |
| pc_wdata | input | AW (16) | Program counter write value |
| psr_wr | input | 1 | Status word write strobe |
| psr_wdata | input | 16 | Status word write value |
| pc | output | AW (16) | Program counter |
| psr | output | 16 | Status word |

## Verification
A state machine stuck or skipping a step shows at once at the ports: `ack` and `mem_rd` together give away the current phase, and `proceed` must stay dead between them. A wrong save register shows only one cycle after a `ret`, when `pc` or the flag and reserved bits come back altered. A wrong vector offset shows on `mem_addr` in the cycle after capture, or on the second read. The bench therefore compares `pc` and `psr` at every phase change, and again after the return, for each vector, latency and enable pattern.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int AW = 16,
  parameter int VW = 10,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          irq,
  output logic          proceed,
  output logic          ack,
  input  logic          vec_valid,
  input  logic [VW-1:0] vec_data,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic          ret,
  input  logic          pc_wr,
  input  logic [AW-1:0] pc_wdata,
  input  logic          psr_wr,
  input  logic [15:0]   psr_wdata,
  output logic [AW-1:0] pc,
  output logic [15:0]   psr
);
  localparam int PRIO_W = 3;
  localparam int EN_BIT = 3;

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_HND, S_PRI} state_t;

  state_t        st;
  logic [AW-1:0] vec_q, spc;
  logic [15:0]   spsr;
  logic          idle, take;

  assign idle     = (st == S_IDLE);
  assign take     = idle && !ret && boundary && irq && psr[EN_BIT];
  assign proceed  = idle && !ret && boundary && !(irq && psr[EN_BIT]);
  assign ack      = (st == S_ACK);
  assign mem_rd   = (st == S_HND) || (st == S_PRI);
  assign mem_addr = (st == S_PRI) ? vec_q + AW'(1) : vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pc    <= RESET_PC;
      psr   <= '0;
      spc   <= RESET_PC;
      spsr  <= '0;
      vec_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ret) begin
            pc  <= spc;
            psr <= spsr;
          end else if (take) begin
            spc         <= pc;
            spsr        <= psr;
            psr[EN_BIT] <= 1'b0;
            st          <= S_ACK;
          end else begin
            if (pc_wr)  pc  <= pc_wdata;
            if (psr_wr) psr <= psr_wdata;
          end
        end
        S_ACK: begin
          if (vec_valid) begin
            vec_q <= {{(AW-VW){1'b0}}, vec_data};
            st    <= S_HND;
          end
        end
        S_HND: begin
          if (mem_ready) begin
            pc <= mem_rdata;
            st <= S_PRI;
          end
        end
        S_PRI: begin
          if (mem_ready) begin
            psr[PRIO_W-1:0] <= mem_rdata[PRIO_W-1:0];
            psr[EN_BIT]     <= 1'b1;
            st              <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module irq_entry_seq_chk #(
  parameter int AW = 16,
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary,
  input logic          irq,
  input logic          proceed,
  input logic          ack,
  input logic          vec_valid,
  input logic [VW-1:0] vec_data,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          ret,
  input logic [AW-1:0] pc,
  input logic [15:0]   psr
);
  a_r2_proceed_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    proceed |=> !ack);

  a_r3_take_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !mem_rd && !ret && boundary && irq && psr[3]) |=> (ack && !psr[3]));

  a_r4_vector_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && vec_valid) |=> (!ack && mem_rd && mem_addr == {{(AW-VW){1'b0}}, $past(vec_data)}));

  a_r5_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr) && $stable(pc)));

  a_r6_enable_back: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd) |-> psr[3]);

  a_r9_no_proceed_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || mem_rd) |-> !proceed);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .irq(irq), .proceed(proceed),
  .ack(ack), .vec_valid(vec_valid), .vec_data(vec_data), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .mem_ready(mem_ready), .ret(ret), .pc(pc), .psr(psr)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
  logic        clk = 0, rst_n = 0;
  logic        boundary = 0, irq = 0, vec_valid = 0, ret = 0, pc_wr = 0, psr_wr = 0;
  logic [9:0]  vec_data = '0;
  logic [15:0] mem_rdata, pc_wdata = '0, psr_wdata = '0;
  logic        mem_ready, proceed, ack, mem_rd;
  logic [15:0] mem_addr, pc, psr;

  int checks = 0, errors = 0;
  logic [9:0]  cur_vec = '0;
  logic [15:0] cur_hnd = '0;
  logic [2:0]  cur_prio = '0;
  int          lat = 0, cnt = 0;

  always #10 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .irq(irq), .proceed(proceed),
    .ack(ack), .vec_valid(vec_valid), .vec_data(vec_data), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .ret(ret),
    .pc_wr(pc_wr), .pc_wdata(pc_wdata), .psr_wr(psr_wr), .psr_wdata(psr_wdata),
    .pc(pc), .psr(psr));

  // memory model: handler at vector, priority word (junk upper bits) at vector+1
  assign mem_rdata = (mem_addr == {6'b0, cur_vec}) ? cur_hnd : (16'hFFF8 | {13'b0, cur_prio});
  assign mem_ready = mem_rd && (cnt == lat);
  always @(posedge clk) begin
    if (mem_rd && mem_ready) cnt <= 0;
    else if (mem_rd)         cnt <= cnt + 1;
    else                     cnt <= 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // cases: {irq, en, lat, prio, vec, handler}
  localparam logic [32:0] CASES [7] = '{
    {1'b1, 1'b1, 2'd0, 3'd4, 10'h100, 16'h8000},
    {1'b1, 1'b1, 2'd3, 3'd7, 10'h3FF, 16'hBEEF},
    {1'b1, 1'b1, 2'd1, 3'd5, 10'h000, 16'h0042},
    {1'b0, 1'b1, 2'd0, 3'd6, 10'h020, 16'h1111},
    {1'b1, 1'b0, 2'd0, 3'd6, 10'h020, 16'h1111},
    {1'b0, 1'b0, 2'd0, 3'd6, 10'h020, 16'h1111},
    {1'b1, 1'b1, 2'd2, 3'd6, 10'h0FE, 16'hFFFE}
  };

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk(pc == 16'h0 && psr == 16'h0 && !ack && !mem_rd && !proceed, "R1", {pc, psr}, 32'h0);
    rst_n = 1;
    tick();

    foreach (CASES[i]) begin
      logic c_irq, c_en;
      logic [15:0] base_psr;
      bit seen;
      c_irq    = CASES[i][32];
      c_en     = CASES[i][31];
      lat      = int'(CASES[i][30:29]);
      cur_prio = CASES[i][28:26];
      cur_vec  = CASES[i][25:16];
      cur_hnd  = CASES[i][15:0];
      base_psr = {8'hA5, 4'b1010, c_en, 3'b010};
      pc_wr = 1; pc_wdata = 16'h1234; psr_wr = 1; psr_wdata = base_psr;
      tick();
      pc_wr = 0; psr_wr = 0;
      chk(pc == 16'h1234 && psr == base_psr, "R8 idle write", {pc, psr}, {16'h1234, base_psr});
      boundary = 1; irq = c_irq; #1;
      chk(proceed == !(c_irq && c_en), "R2/R3 proceed", proceed, !(c_irq && c_en));
      tick();
      boundary = 0; irq = 0;
      if (!(c_irq && c_en)) begin
        chk(!ack && !mem_rd && pc == 16'h1234, "R2 no entry", {ack, mem_rd, pc}, {2'b0, 16'h1234});
      end else begin
        chk(ack && psr == (base_psr & ~16'h0008), "R3 ack and enable cleared", {ack, psr}, {1'b1, base_psr & ~16'h0008});
        tick();
        chk(ack && !mem_rd, "R4 ack held without vector", {ack, mem_rd}, 2'b10);
        vec_valid = 1; vec_data = cur_vec;
        tick();
        vec_valid = 0; vec_data = 10'h2AA;
        chk(!ack && mem_rd && mem_addr == {6'b0, cur_vec}, "R4 vector read", {ack, mem_rd, mem_addr}, {2'b01, 6'b0, cur_vec});
        if (lat > 0) chk(pc == 16'h1234, "R5 pc held while waiting", pc, 16'h1234);
        seen = 0;
        for (int k = 0; k < 20 && mem_rd; k++) begin
          tick();
          if (!seen && mem_rd && mem_addr == {6'b0, cur_vec} + 16'd1) begin
            seen = 1;
            chk(pc == cur_hnd && !psr[3], "R5 handler loaded", pc, cur_hnd);
          end
        end
        chk(seen, "R5 second read at vector+1", seen, 1);
        chk(!mem_rd && pc == cur_hnd && psr == {8'hA5, 4'b1010, 1'b1, cur_prio}, "R6 priority and enable",
            {pc, psr}, {cur_hnd, 8'hA5, 4'b1010, 1'b1, cur_prio});
        ret = 1;
        tick();
        ret = 0;
        chk(pc == 16'h1234 && psr == base_psr, "R7 restore", {pc, psr}, {16'h1234, base_psr});
      end
    end

    // R8/R9: writes, ret and boundary during entry have no effect
    cur_vec = 10'h010; cur_hnd = 16'h2222; cur_prio = 3'd5; lat = 0;
    pc_wr = 1; pc_wdata = 16'h0777; psr_wr = 1; psr_wdata = 16'h00F8;
    tick();
    pc_wr = 0; psr_wr = 0;
    boundary = 1; irq = 1;
    tick();
    pc_wr = 1; pc_wdata = 16'hDEAD; psr_wr = 1; psr_wdata = 16'h0000; ret = 1; #1;
    chk(!proceed, "R9 no proceed during entry", proceed, 0);
    tick();
    pc_wr = 0; psr_wr = 0; ret = 0; boundary = 0; irq = 0;
    chk(ack && pc == 16'h0777 && psr == 16'h00F0, "R8 ignored during entry", {pc, psr}, {16'h0777, 16'h00F0});
    vec_valid = 1; vec_data = cur_vec;
    tick();
    vec_valid = 0;
    for (int k = 0; k < 10 && mem_rd; k++) tick();
    chk(pc == 16'h2222 && psr == 16'h00FD, "R6 after ignored writes", {pc, psr}, {16'h2222, 16'h00FD});

    // R7: ret wins over a boundary with a pending interrupt
    ret = 1; boundary = 1; irq = 1; #1;
    chk(!proceed, "R7 boundary ignored on ret", proceed, 0);
    tick();
    ret = 0; boundary = 0; irq = 0;
    chk(!ack && pc == 16'h0777 && psr == 16'h00F8, "R7 restore without entry", {ack, pc, psr}, {1'b0, 16'h0777, 16'h00F8});

    // R1: reset in the middle of an entry
    boundary = 1; irq = 1;
    tick();
    boundary = 0; irq = 0;
    rst_n = 0;
    tick();
    chk(!ack && !mem_rd && pc == 16'h0 && psr == 16'h0, "R1 reset mid-entry", {ack, pc, psr}, 33'h0);
    rst_n = 1;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule